// File: doc/BRIEF.md
# Bus-Programmed Output-Enable Register Slave

This block is a two-wire serial bus slave (I2C protocol) holding a single eight-bit control byte. Each bit of the byte decides whether one of eight clock output pairs is driven or parked in high impedance. A bit at 0 keeps its output running and a bit at 1 floats it. Reset clears the byte, so every output runs until a controller writes a new value.

The device address has seven bits. The upper five are a fixed prefix (binary 11010). The lower two come from strap pins, the higher strap first, so up to four copies can share a bus. There is no register pointer. A write is the address with the direction bit low, then one data byte. A read is the address with the direction bit high, and the slave returns the byte most significant bit first. SCL and SDA are sampled by the system clock through synchronizer chains, and start and stop conditions are found from the synchronized samples. The slave pulls SDA low through an open-drain enable.

Top module: `clkOeSlave`

## Requirements
- R1: The slave responds only to the address byte whose upper seven bits are 1,1,0,1,0,strap[1],strap[0], sent MSB first; bit 0 of that byte is the direction (0 write, 1 read). A byte with any other address leaves SDA released in the acknowledge slot.
- R2: A matching address is acknowledged by holding SDA low for the whole ninth SCL clock.
- R3: In a write, the first data byte after the address is acknowledged and loaded; outHiZ[n] then equals data bit n (bit 7 is the first bit sent).
- R4: outEnable[n] is the inverse of outHiZ[n]: a stored 1 marks output n high-impedance and a stored 0 enables it.
- R5: After reset, outHiZ is 8'h00, outEnable is 8'hFF, and SDA is not driven.
- R6: A read returns the stored byte MSB first on SDA, and SDA is released for the controller's acknowledge slot.
- R7: After the acknowledge slot of a read, the slave keeps SDA released until the next START or STOP.
- R8: A second data byte in the same write is not acknowledged and does not change the stored byte.
- R9: A repeated START in the middle of a byte discards the partial byte and begins address reception again.
- R10: After a non-matching address, data bytes that follow are ignored and the stored byte is unchanged.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| strap | input | 2 | Low two bits of the device address |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| outEnable | output | 8 | Per-output enable, 1 = output driven |
| outHiZ | output | 8 | Per-output tri-state control, 1 = high impedance |

## Verification
The hardest case to reach from the pins is a START that arrives partway through a byte. The bench sends four bits and then, with SCL low, raises SDA, raises SCL and drops SDA. It then sends a full read address and checks that the byte returned is the stored one. A second hard case is a transfer addressed to another device that carries a data byte. It is reached by changing the strap pins between transactions, so one fixed prefix misses in one pass and hits in the next.

// File: rtl/clkOePkg.sv
package clkOePkg;
  typedef struct packed {
    logic shiftIn;
    logic commit;
    logic loadTx;
    logic shiftTx;
  } dpStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } busState_t;
endpackage

// File: rtl/clkOeSync.sv
module clkOeSync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] syncOut
);
  logic [LINES-1:0] chain [STAGES];

  // Bus lines idle high, so the chain resets to 1.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= rawIn;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/clkOeData.sv
module clkOeData
  import clkOePkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strb,
  input  logic               sdaS,
  output logic [NUM_OUT-1:0] rxByte,
  output logic               txMsb,
  output logic [NUM_OUT-1:0] outEnable,
  output logic [NUM_OUT-1:0] outHiZ
);
  logic [NUM_OUT-1:0] rxShift;
  logic [NUM_OUT-1:0] cfgReg;
  logic [NUM_OUT-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      cfgReg  <= '0;
      txShift <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[NUM_OUT-2:0], sdaS};
      if (strb.commit)  cfgReg  <= rxShift;
      if (strb.loadTx)       txShift <= cfgReg;
      else if (strb.shiftTx) txShift <= {txShift[NUM_OUT-2:0], 1'b0};
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[NUM_OUT-1];

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      assign outHiZ[i]    = cfgReg[i];
      assign outEnable[i] = ~cfgReg[i];
    end
  endgenerate
endmodule

// File: rtl/clkOeCtrl.sv
module clkOeCtrl
  import clkOePkg::*;
#(
  parameter int           NUM_OUT    = 8,
  parameter int           STRAP_BITS = 2,
  parameter logic [6-STRAP_BITS:0] DEV_PREFIX = 5'b11010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclS,
  input  logic                  sdaS,
  input  logic [STRAP_BITS-1:0] strap,
  input  logic [NUM_OUT-1:0]    rxByte,
  input  logic                  txMsb,
  output dpStrobes_t            strb,
  output logic                  sdaOe,
  output busState_t             state
);
  localparam int CNT_W = $clog2(NUM_OUT + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(NUM_OUT);

  logic             sclPrev, sdaPrev, isRead;
  logic [CNT_W-1:0] bitCnt;
  busState_t        nextState;
  logic [CNT_W-1:0] nextCnt;
  logic             nextRead;
  logic             sclRise, sclFall, startSeen, stopSeen, addrHit;

  always_comb begin
    sclRise   = sclS & ~sclPrev;
    sclFall   = ~sclS & sclPrev;
    startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
    stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
    addrHit   = rxByte[7:1] == {DEV_PREFIX, strap};
  end

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    nextRead  = isRead;
    strb      = '0;
    if (startSeen) begin
      nextState = ST_ADDR;
      nextCnt   = '0;
    end else if (stopSeen) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR_DATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            nextCnt      = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            if (state == ST_WR_DATA) begin
              strb.commit = 1'b1;
              nextState   = ST_WR_ACK;
            end else if (addrHit) begin
              nextRead  = rxByte[0];
              nextState = ST_ADDR_ACK;
            end else begin
              nextState = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          nextCnt = '0;
          if (isRead) begin
            strb.loadTx = 1'b1;
            nextState   = ST_RD_DATA;
          end else begin
            nextState = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (sclRise) nextCnt = bitCnt + 1'b1;
          else if (sclFall) begin
            if (bitCnt == LAST_BIT) nextState = ST_RD_ACK;
            else strb.shiftTx = 1'b1;
          end
        end
        ST_WR_ACK, ST_RD_ACK: if (sclFall) nextState = ST_IGNORE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isRead  <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      state   <= nextState;
      bitCnt  <= nextCnt;
      isRead  <= nextRead;
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 ((state == ST_RD_DATA) && !txMsb);
endmodule

// File: rtl/clkOeSlave.sv
module clkOeSlave
  import clkOePkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int STRAP_BITS  = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [6-STRAP_BITS:0] DEV_PREFIX = 5'b11010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [STRAP_BITS-1:0] strap,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_OUT-1:0]    outEnable,
  output logic [NUM_OUT-1:0]    outHiZ
);
  logic [1:0]         busSync;
  logic               sclSync, sdaSync, txMsb;
  logic [NUM_OUT-1:0] rxByte;
  dpStrobes_t         strb;
  busState_t          busState;

  clkOeSync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn({sclIn, sdaIn}), .syncOut(busSync));

  assign sclSync = busSync[1];
  assign sdaSync = busSync[0];

  clkOeCtrl #(.NUM_OUT(NUM_OUT), .STRAP_BITS(STRAP_BITS), .DEV_PREFIX(DEV_PREFIX)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclSync), .sdaS(sdaSync), .strap(strap),
    .rxByte(rxByte), .txMsb(txMsb), .strb(strb), .sdaOe(sdaOe), .state(busState));

  clkOeData #(.NUM_OUT(NUM_OUT)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaSync), .rxByte(rxByte),
    .txMsb(txMsb), .outEnable(outEnable), .outHiZ(outHiZ));
endmodule

// File: rtl/clkOeSlaveChk.sv
module clkOeSlaveChk
  import clkOePkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               sclS,
  input logic               sdaOe,
  input busState_t          busState,
  input logic [NUM_OUT-1:0] outHiZ,
  input logic [NUM_OUT-1:0] outEnable
);
  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (outHiZ == '0 && outEnable == '1 && !sdaOe));

  assert_load_during_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outHiZ) |-> sdaOe);

  assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

  assert_quiet_when_ignoring_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IGNORE || busState == ST_IDLE) |-> !sdaOe);

  assert_ignore_holds_reg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IGNORE && $past(busState) == ST_IGNORE) |-> $stable(outHiZ));

  assert_polarity_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outHiZ) |-> !$stable(outEnable));
endmodule

bind clkOeSlave clkOeSlaveChk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclSync), .sdaOe(sdaOe), .busState(busState),
  .outHiZ(outHiZ), .outEnable(outEnable));

// File: tb/clkOeSlave_tb.sv
`timescale 1ns/1ps
module clkOeSlave_tb;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] strap = 2'b10;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaOe;
  logic [7:0] outEnable, outHiZ;
  wire        sdaLine = sdaM & ~sdaOe;

  int checks = 0;
  int errors = 0;
  int clockFails = 0;

  // Behavioural model of the stored byte.
  logic [7:0] expHiZ = 8'h00;
  logic [7:0] pendHiZ = 8'h00;
  bit         settle = 1'b0;
  bit         modelOn = 1'b0;
  logic       prevOe = 1'b0;
  int         sclHighCnt = 0;

  always #4 clk = ~clk;

  clkOeSlave u_dut (
    .clk(clk), .rstN(rstN), .strap(strap), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .outEnable(outEnable), .outHiZ(outHiZ));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R3, R4, R8, R10) and SDA timing (R11).
  always @(negedge clk) begin
    if (modelOn) begin
      logic [7:0] want;
      want = (settle && outHiZ === pendHiZ) ? pendHiZ : expHiZ;
      checks++;
      if (outHiZ !== want || outEnable !== ~want) begin
        errors++;
        if (clockFails < 5)
          $display("FAIL R4 per-clock actual=%0h/%0h expected=%0h/%0h",
                   outHiZ, outEnable, want, ~want);
        clockFails++;
      end
      if (sdaOe !== prevOe) begin
        checks++;
        if (sclM && sclHighCnt > 4) begin
          errors++;
          $display("FAIL R11 actual=sda change with scl high expected=change with scl low");
        end
      end
    end
    prevOe = sdaOe;
    sclHighCnt = sclM ? sclHighCnt + 1 : 0;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic writeBit(logic b);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic masterAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~masterAck);
  endtask

  function automatic logic [7:0] addrByte(logic [1:0] s, logic rd);
    return {5'b11010, s, rd};
  endfunction

  task automatic writeReg(logic [1:0] s, logic [7:0] d, logic willTake, string req);
    logic ack;
    startCond();
    sendByte(addrByte(s, 1'b0), ack);
    check({req, " address ack"}, ack, willTake);
    pendHiZ = willTake ? d : expHiZ;
    settle = 1'b1;
    sendByte(d, ack);
    check({req, " data ack"}, ack, willTake);
    expHiZ = pendHiZ;
    settle = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic ack;
    logic b;
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    check("R5 hiz", outHiZ, 8'h00);
    check("R5 enable", outEnable, 8'hFF);
    check("R5 sda", sdaOe, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    modelOn = 1'b1;

    // R1/R10: address with straps 01 while device strap is 10.
    writeReg(2'b01, 8'hFF, 1'b0, "R1 R10 mismatch");
    stopCond();
    check("R10 hiz kept", outHiZ, 8'h00);

    // R2/R3/R4: matching write.
    writeReg(2'b10, 8'hA5, 1'b1, "R2 R3 write");
    stopCond();
    check("R3 hiz", outHiZ, 8'hA5);
    check("R4 enable", outEnable, 8'h5A);

    // R6/R7: read back, controller NACKs, SDA stays released.
    startCond();
    sendByte(addrByte(2'b10, 1'b1), ack);
    check("R2 read address ack", ack, 1'b1);
    recvByte(rd, 1'b0);
    check("R6 read data", rd, 8'hA5);
    readBit(b);
    check("R7 released after nack", b, 1'b1);
    stopCond();

    // R8: second data byte not acked, register unchanged.
    writeReg(2'b10, 8'h3C, 1'b1, "R8 first");
    pendHiZ = expHiZ;
    settle = 1'b1;
    sendByte(8'hFF, ack);
    settle = 1'b0;
    check("R8 extra byte nack", ack, 1'b0);
    stopCond();
    check("R8 hiz", outHiZ, 8'h3C);

    // R9: repeated START in the middle of a byte.
    startCond();
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b0); writeBit(1'b1);
    startCond();
    sendByte(addrByte(2'b10, 1'b1), ack);
    check("R9 address ack after restart", ack, 1'b1);
    recvByte(rd, 1'b0);
    check("R9 read data", rd, 8'h3C);
    stopCond();

    // R1: straps changed, new address takes the write.
    strap = 2'b01;
    writeReg(2'b01, 8'h81, 1'b1, "R1 strap 01");
    stopCond();
    check("R1 hiz", outHiZ, 8'h81);
    check("R4 enable", outEnable, 8'h7E);
    writeReg(2'b10, 8'h00, 1'b0, "R1 old strap");
    stopCond();
    check("R10 hiz kept", outHiZ, 8'h81);

    // R4: clear all bits back to enabled.
    writeReg(2'b01, 8'h00, 1'b1, "R4 clear");
    stopCond();
    check("R4 all enabled", outEnable, 8'hFF);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule